// File: doc/BRIEF.md
# Packed-Result Integer Divider

This block is a multi-cycle integer divider for a processor execution stage. It runs four operations. Two are short forms: a W-bit dividend divided by a W/2-bit divisor, signed or unsigned, with quotient and remainder packed into one W-bit destination. Two are long forms: a 2W-bit dividend, built from two source registers, divided by a W-bit divisor, with quotient and remainder going to two destinations.

The requester raises `start` for one cycle with the operation code, the operand values and the destination indices. The unit then shows `busy` while it runs a restoring shift-subtract loop that produces one quotient bit per cycle. Signed operands are reduced to magnitudes first, and the signs are applied again at the end. When the operation finishes, the unit returns register writes on a single write port, updates the condition flags N, Z, V and C, and pulses `done`. A zero divisor ends the operation at once with a divide-by-zero exception request and no write.

Top module: `div_unit_packed`

## Requirements
- R1: A zero divisor pulses `div0_req` together with `done`, one cycle after `start`. No register is written and `flags_we` stays low. In the short forms, only the low W/2 bits of `divisor` are tested for zero.
- R2: Whenever `flags_we` is high, `flag_c` is 0. This includes overflow.
- R3: Op code 00 (unsigned) and op code 01 (signed) are short forms. They divide `src_lo` by `divisor[W/2-1:0]` and write `q_idx` once with the remainder in bits W-1:W/2 and the quotient in bits W/2-1:0.
- R4: A short form overflows when its quotient is outside the W/2-bit range. The range is 0..2^(W/2)-1 for op 00 and -2^(W/2-1)..2^(W/2-1)-1 for op 01.
- R5: On overflow the flags are N=1, Z=0, V=1 and C=0, and no register is written.
- R6: Without overflow, V=0, N is the top bit of the result-width quotient (W/2 bits short, W bits long), and Z is set exactly when that quotient is zero.
- R7: Op code 10 (unsigned) and op code 11 (signed) are long forms. They divide {`src_hi`,`src_lo`} by `divisor`, and overflow when the quotient does not fit in W bits (unsigned range for 10, signed range for 11).
- R8: A long form without overflow writes the remainder to `r_idx` in one cycle and the quotient to `q_idx` in the next cycle, the second write with `done`. When the two indices are equal, the quotient is the value left in the register.
- R9: Signed quotients are truncated toward zero, and the remainder takes the sign of the dividend.
- R10: A `start` while `busy` is high is ignored. `busy` is low in the cycle that `done` is high.
- R11: After a synchronous reset, `busy`, `done`, `wr_en`, `flags_we` and `div0_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| op | input | 2 | Operation: bit 1 long form, bit 0 signed |
| src_lo | input | W | Short dividend, or low word of long dividend |
| src_hi | input | W | High word of long dividend |
| divisor | input | W | Divisor (low half used by short forms) |
| q_idx | input | IW | Quotient / packed destination index |
| r_idx | input | IW | Remainder destination index (long forms) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | IW | Register write index |
| wr_data | output | W | Register write data |
| flags_we | output | 1 | Flag update strobe |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| div0_req | output | 1 | Divide-by-zero exception request |

## Verification
A new `start` can arrive in the same cycle as a running division. The bench provokes this by raising `start` with a zero divisor and a different destination while the first division is busy. It judges the result by the modelled register file and the flags: the first operation must complete as it would alone, with no exception request and no write to the second destination. Overflow detection and the two-step long write also meet when the remainder and quotient indices are equal. The sweeps choose equal indices often and check that the overflow case writes nothing and that the normal case leaves the quotient.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    OP_SHORT_U = 2'b00,
    OP_SHORT_S = 2'b01,
    OP_LONG_U  = 2'b10,
    OP_LONG_S  = 2'b11
  } div_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIX,
    ST_WQ
  } div_state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } div_ccr_t;
endpackage

// File: rtl/div_prep.sv
module div_prep #(
  parameter int W = 32
) (
  input  logic [1:0]                    op,
  input  logic [W-1:0]                  src_lo,
  input  logic [W-1:0]                  src_hi,
  input  logic [W-1:0]                  divisor,
  output logic [2*W-1:0]                dvd_aligned,
  output logic [W-1:0]                  dvs_mag,
  output logic                          q_neg,
  output logic                          r_neg,
  output logic                          dvs_zero,
  output logic [$clog2(2*W+1)-1:0]      iters
);
  localparam int HW = W / 2;
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW + 1);

  logic          is_long, sgn;
  logic          sd_s, sv_s, sd_l, sv_l;
  logic [W-1:0]  mag_s;
  logic [HW-1:0] dvs_h, mag_vs;
  logic [DW-1:0] dvd_l, mag_l;
  logic [W-1:0]  mag_vl;

  always_comb begin
    is_long = op[1];
    sgn     = op[0];
    // short form operands
    sd_s   = sgn & src_lo[W-1];
    mag_s  = sd_s ? -src_lo : src_lo;
    dvs_h  = divisor[HW-1:0];
    sv_s   = sgn & dvs_h[HW-1];
    mag_vs = sv_s ? -dvs_h : dvs_h;
    // long form operands
    dvd_l  = {src_hi, src_lo};
    sd_l   = sgn & src_hi[W-1];
    mag_l  = sd_l ? -dvd_l : dvd_l;
    sv_l   = sgn & divisor[W-1];
    mag_vl = sv_l ? -divisor : divisor;

    if (is_long) begin
      dvd_aligned = mag_l;
      dvs_mag     = mag_vl;
      q_neg       = sd_l ^ sv_l;
      r_neg       = sd_l;
      dvs_zero    = (divisor == '0);
      iters       = CW'(DW);
    end else begin
      dvd_aligned = {mag_s, {W{1'b0}}};
      dvs_mag     = {{(W-HW){1'b0}}, mag_vs};
      q_neg       = sd_s ^ sv_s;
      r_neg       = sd_s;
      dvs_zero    = (dvs_h == '0);
      iters       = CW'(W);
    end
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [2*W-1:0]   dvd_in,
  input  logic [W-1:0]     dvs_in,
  output logic [2*W-1:0]   quo,
  output logic [W-1:0]     rem
);
  localparam int DW = 2 * W;

  logic [W-1:0]  rem_r, dvs_r;
  logic [DW-1:0] sh_r, q_r;
  logic [W:0]    trial, diff;
  logic          ge;

  always_comb begin
    trial = {rem_r, sh_r[DW-1]};
    diff  = trial - {1'b0, dvs_r};
    ge    = (trial >= {1'b0, dvs_r});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_r <= '0;
      dvs_r <= '0;
      sh_r  <= '0;
      q_r   <= '0;
    end else if (load) begin
      rem_r <= '0;
      dvs_r <= dvs_in;
      sh_r  <= dvd_in;
      q_r   <= '0;
    end else if (step) begin
      rem_r <= ge ? diff[W-1:0] : trial[W-1:0];
      sh_r  <= {sh_r[DW-2:0], 1'b0};
      q_r   <= {q_r[DW-2:0], ge};
    end
  end

  assign quo = q_r;
  assign rem = rem_r;

  // R10
  load_step_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(load && step));

  // R9
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (rem_r < dvs_r));
endmodule

// File: rtl/div_fix.sv
module div_fix #(
  parameter int W = 32
) (
  input  logic             is_long,
  input  logic             sgn,
  input  logic             q_neg,
  input  logic             r_neg,
  input  logic [2*W-1:0]   quo,
  input  logic [W-1:0]     rem,
  output logic             ovf,
  output logic [W-1:0]     q_out,
  output logic [W-1:0]     r_out,
  output logic             res_n,
  output logic             res_z
);
  localparam int HW = W / 2;
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] ONE     = DW'(1);
  localparam logic [DW-1:0] LIM_SU  = (ONE << HW) - ONE;
  localparam logic [DW-1:0] LIM_SSP = (ONE << (HW - 1)) - ONE;
  localparam logic [DW-1:0] LIM_SSN = (ONE << (HW - 1));
  localparam logic [DW-1:0] LIM_LU  = (ONE << W) - ONE;
  localparam logic [DW-1:0] LIM_LSP = (ONE << (W - 1)) - ONE;
  localparam logic [DW-1:0] LIM_LSN = (ONE << (W - 1));

  logic [DW-1:0] lim;
  logic [W-1:0]  qs, rs;

  always_comb begin
    if (is_long)
      lim = sgn ? (q_neg ? LIM_LSN : LIM_LSP) : LIM_LU;
    else
      lim = sgn ? (q_neg ? LIM_SSN : LIM_SSP) : LIM_SU;
    ovf = (quo > lim);
    qs  = q_neg ? -quo[W-1:0] : quo[W-1:0];
    rs  = r_neg ? -rem : rem;
    if (is_long) begin
      q_out = qs;
      r_out = rs;
      res_n = qs[W-1];
      res_z = (qs == '0);
    end else begin
      q_out = {rs[HW-1:0], qs[HW-1:0]};
      r_out = rs;
      res_n = qs[HW-1];
      res_z = (qs[HW-1:0] == '0);
    end
  end
endmodule

// File: rtl/div_unit_packed.sv
module div_unit_packed #(
  parameter int W  = 32,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [W-1:0]  src_lo,
  input  logic [W-1:0]  src_hi,
  input  logic [W-1:0]  divisor,
  input  logic [IW-1:0] q_idx,
  input  logic [IW-1:0] r_idx,
  output logic          busy,
  output logic          done,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [W-1:0]  wr_data,
  output logic          flags_we,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic          flag_c,
  output logic          div0_req
);
  import div_pkg::*;

  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW + 1);

  div_state_e    state;
  logic [CW-1:0] cnt;
  logic          long_q, sgn_q, qneg_q, rneg_q;
  logic [IW-1:0] qi_q, ri_q;
  logic [W-1:0]  qhold;
  logic          hold_n, hold_z;
  div_ccr_t      ccr;
  logic          done_r, wr_en_r, fwe_r, dz_r;
  logic [IW-1:0] widx_r;
  logic [W-1:0]  wdata_r;

  logic [DW-1:0] p_dvd;
  logic [W-1:0]  p_dvs;
  logic          p_qneg, p_rneg, p_zero;
  logic [CW-1:0] p_iters;
  logic [DW-1:0] c_quo;
  logic [W-1:0]  c_rem;
  logic          f_ovf, f_n, f_z;
  logic [W-1:0]  f_q, f_r;
  logic          accept, load, step;

  div_prep #(.W(W)) u_prep (
    .op(op), .src_lo(src_lo), .src_hi(src_hi), .divisor(divisor),
    .dvd_aligned(p_dvd), .dvs_mag(p_dvs), .q_neg(p_qneg), .r_neg(p_rneg),
    .dvs_zero(p_zero), .iters(p_iters)
  );

  assign accept = (state == ST_IDLE) && start;
  assign load   = accept && !p_zero;
  assign step   = (state == ST_RUN);

  div_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .dvd_in(p_dvd), .dvs_in(p_dvs), .quo(c_quo), .rem(c_rem)
  );

  div_fix #(.W(W)) u_fix (
    .is_long(long_q), .sgn(sgn_q), .q_neg(qneg_q), .r_neg(rneg_q),
    .quo(c_quo), .rem(c_rem), .ovf(f_ovf), .q_out(f_q), .r_out(f_r),
    .res_n(f_n), .res_z(f_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      long_q  <= 1'b0;
      sgn_q   <= 1'b0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      qi_q    <= '0;
      ri_q    <= '0;
      qhold   <= '0;
      hold_n  <= 1'b0;
      hold_z  <= 1'b0;
      ccr     <= '0;
      done_r  <= 1'b0;
      wr_en_r <= 1'b0;
      fwe_r   <= 1'b0;
      dz_r    <= 1'b0;
      widx_r  <= '0;
      wdata_r <= '0;
    end else begin
      done_r  <= 1'b0;
      wr_en_r <= 1'b0;
      fwe_r   <= 1'b0;
      dz_r    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            long_q <= op[1];
            sgn_q  <= op[0];
            qneg_q <= p_qneg;
            rneg_q <= p_rneg;
            qi_q   <= q_idx;
            ri_q   <= r_idx;
            if (p_zero) begin
              done_r <= 1'b1;
              dz_r   <= 1'b1;
            end else begin
              cnt   <= p_iters;
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) state <= ST_FIX;
        end
        ST_FIX: begin
          if (f_ovf) begin
            fwe_r  <= 1'b1;
            ccr    <= '{n: 1'b1, z: 1'b0, v: 1'b1, c: 1'b0};
            done_r <= 1'b1;
            state  <= ST_IDLE;
          end else if (!long_q) begin
            fwe_r   <= 1'b1;
            ccr     <= '{n: f_n, z: f_z, v: 1'b0, c: 1'b0};
            wr_en_r <= 1'b1;
            widx_r  <= qi_q;
            wdata_r <= f_q;
            done_r  <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            wr_en_r <= 1'b1;
            widx_r  <= ri_q;
            wdata_r <= f_r;
            qhold   <= f_q;
            hold_n  <= f_n;
            hold_z  <= f_z;
            state   <= ST_WQ;
          end
        end
        ST_WQ: begin
          fwe_r   <= 1'b1;
          ccr     <= '{n: hold_n, z: hold_z, v: 1'b0, c: 1'b0};
          wr_en_r <= 1'b1;
          widx_r  <= qi_q;
          wdata_r <= qhold;
          done_r  <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = done_r;
  assign wr_en    = wr_en_r;
  assign wr_idx   = widx_r;
  assign wr_data  = wdata_r;
  assign flags_we = fwe_r;
  assign flag_n   = ccr.n;
  assign flag_z   = ccr.z;
  assign flag_v   = ccr.v;
  assign flag_c   = ccr.c;
  assign div0_req = dz_r;

  // R1
  zero_div_chk: assert property (@(posedge clk) disable iff (rst)
    div0_req |-> (done && !wr_en && !flags_we));

  // R5
  ovf_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_we && flag_v) |-> (!wr_en && !$past(wr_en)));

  // R8
  wr_order_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !done) |=> (wr_en && done));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6
  nz_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_we && !flag_v) |-> !(flag_n && flag_z));
endmodule

// File: tb/tb_div_unit_packed.sv
module tb_div_unit_packed;
  localparam int W  = 8;
  localparam int HW = W / 2;
  localparam int IW = 3;
  localparam int NR = 1 << IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    op = 2'b00;
  logic [W-1:0]  src_lo = '0, src_hi = '0, divisor = '0;
  logic [IW-1:0] q_idx = '0, r_idx = '0;
  logic          busy, done, wr_en, flags_we, flag_n, flag_z, flag_v, flag_c, div0_req;
  logic [IW-1:0] wr_idx;
  logic [W-1:0]  wr_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int runs  = 0;
  logic [W-1:0] rf  [NR];
  logic [W-1:0] erf [NR];

  always #4 clk = ~clk;

  div_unit_packed #(.W(W), .IW(IW)) dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .src_lo(src_lo),
    .src_hi(src_hi), .divisor(divisor), .q_idx(q_idx), .r_idx(r_idx),
    .busy(busy), .done(done), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .flags_we(flags_we), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .div0_req(div0_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, got cycle %0d exp below 190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s op=%0d lo=%0h hi=%0h dv=%0h: got %0h exp %0h",
               tag, op, src_lo, src_hi, divisor, got, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [W-1:0] lo,
                        input logic [W-1:0] hi, input logic [W-1:0] dv,
                        input logic [IW-1:0] qi, input logic [IW-1:0] ri,
                        input bit inject);
    longint xs, ds, q, r;
    bit ovf, zero, islong, sgn;
    bit g_fw, g_n, g_z, g_v, g_c, g_dz, fin;
    bit e_n, e_z;
    int k;
    string tag;
    runs++;
    for (int i = 0; i < NR; i++) begin
      rf[i]  = W'(i * 37 + runs * 11 + 5);
      erf[i] = rf[i];
    end
    islong = o[1];
    sgn    = o[0];
    // model
    if (islong) begin
      xs = longint'({hi, lo});
      ds = longint'(dv);
      if (sgn && hi[W-1]) xs = xs - (longint'(1) << (2*W));
      if (sgn && dv[W-1]) ds = ds - (longint'(1) << W);
    end else begin
      xs = longint'(lo);
      ds = longint'(dv[HW-1:0]);
      if (sgn && lo[W-1]) xs = xs - (longint'(1) << W);
      if (sgn && dv[HW-1]) ds = ds - (longint'(1) << HW);
    end
    zero = (ds == 0);
    q = 0; r = 0; ovf = 0;
    if (!zero) begin
      q = xs / ds;
      r = xs % ds;
      if (islong)
        ovf = sgn ? (q > 127 || q < -128) : (q > 255);
      else
        ovf = sgn ? (q > 7 || q < -8) : (q > 15);
    end
    e_n = 0; e_z = 0;
    if (!zero && !ovf) begin
      if (islong) begin
        erf[ri] = W'(r);
        erf[qi] = W'(q);
        e_n = q[W-1];
        e_z = (W'(q) == '0);
      end else begin
        erf[qi] = {r[HW-1:0], q[HW-1:0]};
        e_n = q[HW-1];
        e_z = (q[HW-1:0] == '0);
      end
    end
    if (zero)        tag = "R1 zero divisor";
    else if (ovf)    tag = islong ? "R5 R7 overflow" : "R5 R4 overflow";
    else if (islong) tag = sgn ? "R7 R8 R9 long" : "R7 R8 long";
    else             tag = sgn ? "R3 R9 short" : "R3 short";
    if (inject) tag = {tag, " R10 start while busy"};
    // drive
    @(negedge clk);
    op = o; src_lo = lo; src_hi = hi; divisor = dv; q_idx = qi; r_idx = ri;
    start = 1'b1;
    g_fw = 0; g_n = 0; g_z = 0; g_v = 0; g_c = 0; g_dz = 0; fin = 0;
    k = 0;
    while (!fin && k < 200) begin
      @(negedge clk);
      start = 1'b0;
      if (inject && k == 2) begin
        start = 1'b1; op = 2'b00; src_lo = 8'h05; divisor = '0;
        q_idx = qi + 3'd1;
      end
      if (wr_en) rf[wr_idx] = wr_data;
      if (done) begin
        fin = 1; g_fw = flags_we; g_n = flag_n; g_z = flag_z;
        g_v = flag_v; g_c = flag_c; g_dz = div0_req;
      end
      k++;
    end
    start = 1'b0;
    op = o; src_lo = lo; src_hi = hi; divisor = dv;
    check(fin, {tag, " done"}, 32'(k), 32'(200));
    for (int i = 0; i < NR; i++) begin
      if (rf[i] !== erf[i]) begin
        check(0, {tag, " regfile"}, 32'(rf[i]), 32'(erf[i]));
        break;
      end
      if (i == NR - 1) check(1, tag, 0, 0);
    end
    if (zero)
      check(g_dz && !g_fw, "R1 exception flags", {g_dz, g_fw}, 2'b10);
    else if (ovf)
      check(!g_dz && g_fw && g_n && !g_z && g_v && !g_c, "R5 R2 overflow flags",
            {g_dz, g_fw, g_n, g_z, g_v, g_c}, 6'b011010);
    else
      check(!g_dz && g_fw && g_n == e_n && g_z == e_z && !g_v && !g_c,
            "R6 R2 flags", {g_dz, g_fw, g_n, g_z, g_v, g_c},
            {1'b0, 1'b1, e_n, e_z, 1'b0, 1'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check({busy, done, wr_en, flags_we, div0_req} == 5'b0, "R11 reset",
          {busy, done, wr_en, flags_we, div0_req}, 0);

    // short forms: exhaustive dividend and divisor
    for (int s = 0; s < 2; s++)
      for (int x = 0; x < 256; x++)
        for (int d = 0; d < 16; d++)
          run_op(2'(s), W'(x), 8'h3c, W'(d | ((x & 1) << 6)),
                 IW'(x + d), IW'(x), 1'b0);

    // long forms: sampled dividends, divisor sweep, frequent equal indices
    for (int s = 0; s < 2; s++)
      for (int h = 0; h < 8; h++)
        for (int l = 0; l < 6; l++)
          for (int dk = 0; dk < 20; dk++) begin
            logic [W-1:0] hv, dv;
            case (h)
              0: hv = 8'h00; 1: hv = 8'h01; 2: hv = 8'h02; 3: hv = 8'h03;
              4: hv = 8'h7f; 5: hv = 8'h80; 6: hv = 8'hfe; default: hv = 8'hff;
            endcase
            case (dk)
              16: dv = 8'h01; 17: dv = 8'h02; 18: dv = 8'h80; 19: dv = 8'h7f;
              default: dv = W'(dk * 17);
            endcase
            run_op(2'(2 + s), W'(l * 51), hv, dv, IW'(l + dk),
                   (dk % 3 == 0) ? IW'(l + dk) : IW'(l + dk + 1), 1'b0);
          end

    // R10: start pulses while busy are ignored
    run_op(2'b00, 8'd200, 8'h00, 8'h07, 3'd2, 3'd2, 1'b1);
    run_op(2'b11, 8'h34, 8'hf0, 8'h15, 3'd4, 3'd5, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule